// File: doc/BRIEF.md
# Processor Run/Halt Control Unit

This block owns the run/halt control of a small embedded processor core. Software reaches a single 32-bit control word through a one-cycle register port. It sets an enable bit that decides whether the core's fetch stage may fetch new instructions. A soft-reset bit sends the program counter back to a programmable start address. The block watches a few strobes from the core's execution stage. When software, or a halt instruction, withdraws the enable, the core stops at a safe point. A multi-cycle instruction that has already finished its first cycle drains to completion. Anything else is frozen in place at once.

The enable bit shows what was requested, not what the core is doing. It can also change under the core's own activity: a halt instruction clears it. A separate read-only run-state bit reports whether the core is really executing. A halt keeps all core state, so re-enabling resumes at the exact instruction where execution stopped, with no program-counter reset.

Control word layout: bit 0 is the active-low soft reset, bit 1 is the enable, bit 15 is the read-only run state, and bits 31:16 hold the start address. All other bits are unimplemented.

Top module: `runctl_unit`

## Requirements
- R1: Writing the control word with bit 1 = 1 sets the enable bit, and writing it with bit 1 = 0 clears it. The bit reads back the new value from the cycle after the write. While the enable bit is 1 and no soft reset is in progress, `fetch_en` is 1.
- R2: `fetch_en` is 0 in every cycle in which the enable bit reads 0.
- R3: The enable bit may be cleared while a multi-cycle instruction is past its first cycle. This means `first_done` was seen, in that cycle or earlier, and `instr_done` has not yet followed. In that case `core_hold` stays 0 up to and including the cycle in which `instr_done` is high. `core_hold` is 1 from the next cycle.
- R4: If the enable bit is cleared at any other time, `fetch_en` is 0 and `core_hold` is 1 from the cycle after the clearing edge.
- R5: A cycle with `halt_op` high clears the enable bit, seen from the next cycle, unless a register write occurs in the same cycle. In that case the written bit 1 wins.
- R6: Bit 15 (run state) reads 1 in the cycle after any cycle with `fetch_en` high. It reads 0 in the cycle after any cycle in which `fetch_en` is 0 and no draining instruction holds `mc_busy` high. Writes to bit 15 have no effect.
- R7: Writing bit 0 = 0 raises `pc_rst_pulse` for exactly one cycle, the cycle after the write. During that cycle bit 0 reads 0 and `fetch_en` is 0. Bit 0 reads 1 at all other times.
- R8: Setting the enable bit again after a halt clears `core_hold` and raises `fetch_en` from the next cycle, without any `pc_rst_pulse`.
- R9: Bits 31:16 store the start address. The low PC_W bits are writable and drive `pc_start`, and the bits above them read 0.
- R10: After reset the control word reads 0x0000_0001, `fetch_en` is 0, `core_hold` is 1 and `pc_rst_pulse` is 0. Bits 14:2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control word (combinational from state) |
| first_done | input | 1 | Strobe: a multi-cycle instruction finished its first cycle |
| mc_busy | input | 1 | A multi-cycle instruction occupies the execution stage |
| instr_done | input | 1 | Strobe: the current instruction completed |
| halt_op | input | 1 | Strobe: the core executed a halt instruction |
| fetch_en | output | 1 | Fetch stage may issue new fetches |
| core_hold | output | 1 | Freeze any in-flight instruction in place |
| pc_rst_pulse | output | 1 | One-cycle request to load the start address into the PC |
| pc_start | output | PC_W | Programmed start address |

## Verification
The bench focuses on the boundary of the drain decision. A disable that arrives in the same cycle as `first_done` must drain. A design that sampled only the registered flag would freeze the instruction mid-flight. A disable during a first cycle must freeze immediately, and a design that always drained would let the core run on. The bench also drives a halt instruction and a register write in the same cycle, where a wrong priority loses the software's enable. The soft-reset pulse width and the run-state bit lagging one cycle behind fetch are checked on every clock against a behavioural model. A stretched pulse or a run bit copied from the enable bit shows up there as a mismatch.

// File: rtl/runctl_pkg.sv
package runctl_pkg;
  localparam int CTL_W    = 32;
  localparam int SRST_BIT = 0;
  localparam int EN_BIT   = 1;
  localparam int RUN_BIT  = 15;
  localparam int ADDR_LSB = 16;
  localparam int ADDR_W   = 16;

  // Assemble the readable control word from its fields.
  function automatic logic [CTL_W-1:0] pack_ctl(input logic srst_n,
                                                input logic en,
                                                input logic run,
                                                input logic [ADDR_W-1:0] addr);
    logic [CTL_W-1:0] w;
    w = '0;
    w[SRST_BIT] = srst_n;
    w[EN_BIT]   = en;
    w[RUN_BIT]  = run;
    w[ADDR_LSB +: ADDR_W] = addr;
    return w;
  endfunction

  // Next enable value: a write wins over a halt instruction.
  function automatic logic next_enable(input logic cur, input logic wr,
                                       input logic wbit, input logic halt);
    logic n;
    n = cur;
    if (halt) n = 1'b0;
    if (wr)   n = wbit;
    return n;
  endfunction
endpackage

// File: rtl/runctl_regs.sv
module runctl_regs
  import runctl_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [CTL_W-1:0] reg_wdata,
  input  logic             halt_op,
  output logic             en_q,
  output logic             en_next,
  output logic             srst_q,
  output logic             srst_set,
  output logic [PC_W-1:0]  start_addr
);
  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  assign en_next  = next_enable(en_q, reg_wr, reg_wdata[EN_BIT], halt_op);
  assign srst_set = reg_wr && !reg_wdata[SRST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      srst_q     <= 1'b0;
      start_addr <= '0;
    end else begin
      en_q   <= en_next;
      srst_q <= srst_set;
      if (reg_wr) start_addr <= reg_wdata[ADDR_LSB +: PC_W];
    end
  end
endmodule

// File: rtl/runctl_drain.sv
module runctl_drain (
  input  logic clk,
  input  logic rst_n,
  input  logic en_q,
  input  logic en_next,
  input  logic srst_set,
  input  logic first_done,
  input  logic instr_done,
  output logic drain_q
);
  logic past_first_q;
  logic past_first;
  logic en_fall;
  logic pf_next;
  logic drain_next;

  assign past_first = past_first_q || first_done;
  assign en_fall    = en_q && !en_next;

  always_comb begin
    pf_next = past_first_q;
    if (first_done) pf_next = 1'b1;
    if (instr_done || srst_set) pf_next = 1'b0;
  end

  always_comb begin
    drain_next = drain_q;
    if (srst_set || en_next)                    drain_next = 1'b0;
    else if (en_fall && past_first && !instr_done) drain_next = 1'b1;
    else if (instr_done)                        drain_next = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_first_q <= 1'b0;
      drain_q      <= 1'b0;
    end else begin
      past_first_q <= pf_next;
      drain_q      <= drain_next;
    end
  end
endmodule

// File: rtl/runctl_runstate.sv
module runctl_runstate (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_en,
  input  logic drain_q,
  input  logic mc_busy,
  output logic run_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= fetch_en || (drain_q && mc_busy);
  end
endmodule

// File: rtl/runctl_unit.sv
module runctl_unit
  import runctl_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             first_done,
  input  logic             mc_busy,
  input  logic             instr_done,
  input  logic             halt_op,
  output logic             fetch_en,
  output logic             core_hold,
  output logic             pc_rst_pulse,
  output logic [PC_W-1:0]  pc_start
);
  logic en_q, en_next, srst_q, srst_set;
  logic drain_active;
  logic run_q;
  logic [PC_W-1:0] start_addr;

  runctl_regs #(.PC_W(PC_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .halt_op(halt_op), .en_q(en_q), .en_next(en_next), .srst_q(srst_q),
    .srst_set(srst_set), .start_addr(start_addr)
  );

  runctl_drain drain_i (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .en_next(en_next),
    .srst_set(srst_set), .first_done(first_done), .instr_done(instr_done),
    .drain_q(drain_active)
  );

  runctl_runstate run_i (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .drain_q(drain_active),
    .mc_busy(mc_busy), .run_q(run_q)
  );

  assign fetch_en     = en_q && !srst_q;
  assign core_hold    = !fetch_en && !drain_active;
  assign pc_rst_pulse = srst_q;
  assign pc_start     = start_addr;
  assign reg_rdata    = pack_ctl(!srst_q, en_q, run_q, ADDR_W'(start_addr));
endmodule

// File: rtl/runctl_unit_chk.sv
module runctl_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        halt_op,
  input logic        fetch_en,
  input logic        core_hold,
  input logic        pc_rst_pulse,
  input logic        drain_active
);
  p_wr_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[1]) |=> reg_rdata[1]);

  p_no_fetch_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[1] |-> !fetch_en);

  p_drain_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drain_active |-> (!core_hold && !fetch_en));

  p_halt_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_op && !reg_wr) |=> !reg_rdata[1]);

  p_run_follows_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |=> reg_rdata[15]);

  p_run_low_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_en && !drain_active) |=> !reg_rdata[15]);

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_rst_pulse && !(reg_wr && !reg_wdata[0])) |=> !pc_rst_pulse);

  p_pulse_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_rst_pulse |-> (!fetch_en && !reg_rdata[0]));

  p_unimpl_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(reg_rdata[14:2]) == 0);
endmodule

bind runctl_unit runctl_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .halt_op(halt_op), .fetch_en(fetch_en),
  .core_hold(core_hold), .pc_rst_pulse(pc_rst_pulse),
  .drain_active(drain_active)
);

// File: tb/runctl_unit_tb.sv
`timescale 1ns/1ps
module runctl_unit_tb_top;
  localparam int PC_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic first_done = 1'b0, mc_busy = 1'b0, instr_done = 1'b0, halt_op = 1'b0;
  logic fetch_en, core_hold, pc_rst_pulse;
  logic [PC_W-1:0] pc_start;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  runctl_unit #(.PC_W(PC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .first_done(first_done), .mc_busy(mc_busy),
    .instr_done(instr_done), .halt_op(halt_op), .fetch_en(fetch_en),
    .core_hold(core_hold), .pc_rst_pulse(pc_rst_pulse), .pc_start(pc_start)
  );

  // Behavioural reference: requested enable, pending reset, drain flag,
  // "instruction past first cycle" flag, run bit, stored address.
  int m_en = 0, m_rst = 0, m_drain = 0, m_past = 0, m_run = 0, m_addr = 0;

  function automatic int exp_fetch();
    return (m_en != 0 && m_rst == 0) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_rst = 0; m_drain = 0; m_past = 0; m_run = 0; m_addr = 0;
    end else begin
      int f, new_en, was_past, rst_req;
      f = exp_fetch();
      new_en = m_en;
      if (halt_op) new_en = 0;
      if (reg_wr) new_en = reg_wdata[1];
      rst_req = (reg_wr && !reg_wdata[0]) ? 1 : 0;
      was_past = (m_past != 0 || first_done) ? 1 : 0;
      m_run = (f != 0 || (m_drain != 0 && mc_busy)) ? 1 : 0;
      if (rst_req != 0 || new_en != 0) m_drain = 0;
      else if (m_en != 0 && new_en == 0 && was_past != 0 && !instr_done) m_drain = 1;
      else if (instr_done) m_drain = 0;
      if (first_done) m_past = 1;
      if (instr_done || rst_req != 0) m_past = 0;
      if (reg_wr) m_addr = int'(reg_wdata[16 +: PC_W]);
      m_en = new_en;
      m_rst = rst_req;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] exp_word;
      exp_word = 32'(m_addr) << 16;
      exp_word[15] = 1'(m_run);
      exp_word[1]  = 1'(m_en);
      exp_word[0]  = (m_rst == 0);
      chk("R1/R2 fetch_en", 32'(fetch_en), 32'(exp_fetch()));
      chk("R3/R4 core_hold", 32'(core_hold),
          32'((exp_fetch() == 0 && m_drain == 0) ? 1 : 0));
      chk("R7 pc_rst_pulse", 32'(pc_rst_pulse), 32'(m_rst));
      chk("R6/R10 control word", reg_rdata, exp_word);
      chk("R9 pc_start", 32'(pc_start), 32'(m_addr));
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    reg_wr = 0; first_done = 0; mc_busy = 0; instr_done = 0; halt_op = 0;
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1; reg_wdata = d;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk("R10 reset word", reg_rdata, 32'h0000_0001);
    chk("R10 reset fetch", 32'(fetch_en), 0);
    chk("R10 reset hold", 32'(core_hold), 1);
    chk("R10 reset pulse", 32'(pc_rst_pulse), 0);

    // R1/R9: enable with a start address
    wr(32'h0123_0003); step(); idle();
    chk("R1 enable set", 32'(fetch_en), 1);
    chk("R9 start addr", 32'(pc_start), 32'h123);
    chk("R6 run lags fetch", 32'(reg_rdata[15]), 0);
    step();
    chk("R6 run high", reg_rdata, 32'h0123_8003);

    // R3: disable after first cycle -> drain
    mc_busy = 1; first_done = 1; step();
    first_done = 0; wr(32'h0123_0001); step(); reg_wr = 0;
    chk("R3 drain fetch off", 32'(fetch_en), 0);
    chk("R3 drain no hold", 32'(core_hold), 0);
    step();
    chk("R3 still draining", 32'(core_hold), 0);
    chk("R6 run while draining", 32'(reg_rdata[15]), 1);
    instr_done = 1; step(); idle();
    chk("R3 hold after done", 32'(core_hold), 1);
    step();
    chk("R6 run low after drain", 32'(reg_rdata[15]), 0);

    // R3 boundary: disable in the same cycle as first_done
    wr(32'h0123_0003); step(); idle();
    mc_busy = 1; first_done = 1; wr(32'h0123_0001); step(); idle();
    mc_busy = 1;
    chk("R3 same-cycle first_done drains", 32'(core_hold), 0);
    instr_done = 1; step(); idle();
    chk("R3 hold after same-cycle drain", 32'(core_hold), 1);

    // R8 resume, R4 immediate halt in first cycle
    wr(32'h0123_0003); step(); idle();
    chk("R8 resume fetch", 32'(fetch_en), 1);
    chk("R8 resume no hold", 32'(core_hold), 0);
    chk("R8 no pc reset", 32'(pc_rst_pulse), 0);
    step();
    mc_busy = 1; wr(32'h0123_0001); step(); reg_wr = 0;
    chk("R4 immediate hold", 32'(core_hold), 1);
    chk("R4 immediate fetch off", 32'(fetch_en), 0);
    step(); idle();
    chk("R6 run low when frozen", 32'(reg_rdata[15]), 0);

    // R5 halt instruction, and write priority
    wr(32'h0123_0003); step(); idle();
    halt_op = 1; step(); idle();
    chk("R5 halt clears enable", 32'(reg_rdata[1]), 0);
    chk("R2 no fetch after halt", 32'(fetch_en), 0);
    halt_op = 1; wr(32'h0123_0003); step(); idle();
    chk("R5 write beats halt", 32'(reg_rdata[1]), 1);
    step();

    // R7 soft reset
    wr(32'h0123_0002); step(); idle();
    chk("R7 pulse high", 32'(pc_rst_pulse), 1);
    chk("R7 bit0 low during reset", 32'(reg_rdata[0]), 0);
    chk("R7 fetch blocked", 32'(fetch_en), 0);
    step();
    chk("R7 pulse one cycle", 32'(pc_rst_pulse), 0);
    chk("R7 run cleared", 32'(reg_rdata[15]), 0);
    chk("R7 fetch back", 32'(fetch_en), 1);

    // R10/R6: unimplemented bits and run bit ignore writes
    halt_op = 1; step(); idle(); step();
    wr(32'hFFFF_FFFD); step(); idle();
    chk("R10 unimplemented read zero", reg_rdata, 32'h0FFF_0001);

    // Random phase, checked against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      reg_wr     = ($urandom_range(0, 5) == 0);
      reg_wdata  = $urandom;
      if ($urandom_range(0, 7) != 0) reg_wdata[0] = 1'b1;
      if ($urandom_range(0, 2) != 0) reg_wdata[1] = 1'b1;
      mc_busy    = $urandom_range(0, 1);
      first_done = ($urandom_range(0, 3) == 0);
      instr_done = ($urandom_range(0, 3) == 0);
      halt_op    = ($urandom_range(0, 15) == 0);
      step();
    end
    idle();
    step();
    finish_run();
  end
endmodule